// File: doc/BRIEF.md
# Device-Presence Power-Down Monitor

This block sits beside a serial storage port PHY. Once the link has been brought up and a start pulse arrives, it watches a 4-bit detection field in the link status word. A nonzero field means a device is attached. If the field stays zero through a limited series of re-checks, the block gives up and raises a power-down request. The request sets one bit of the PHY control word, so the PHY drops into its low-power state when no device is fitted.

The re-checks are spaced a fixed number of milliseconds apart. The block derives its own millisecond tick from a parameter that gives the system clock rate. Each run ends with a one-cycle done pulse and with either a present flag or an absent flag. The flag holds until the next start. After an absent result, the power-down request stays set until reset, even if later runs find a device.

Top module: `dev_presence_monitor`

## Requirements
- R1: `msTick` is a one-cycle pulse. While idle it repeats every TICK = CLK_HZ/1000 clock cycles, and it restarts its count whenever a wait between checks begins.
- R2: A `start` pulse sampled while idle begins a run. The first check samples `linkStatus` at the next clock edge. A `start` during a run has no effect on its timing or result.
- R3: A check finds a device when `linkStatus[3:0]` is nonzero. The run then ends at once with `done` high for one cycle and `presentFlag` high.
- R4: Bits of `linkStatus` above bit 3 are ignored. A status with only upper bits set counts as no device.
- R5: Consecutive checks are SPACING_MS*TICK+1 cycles apart. Check k (counting from 0) samples at edge 1+k*(SPACING_MS*TICK+1) after the start edge.
- R6: A run makes MAX_RETRY+1 checks in all. A device seen on the final check gives a present result.
- R7: If the final check still finds a zero field, `done` and `absentFlag` rise together and `pdReq` rises in the same cycle.
- R8: `ctrlOut` equals `ctrlIn` with bit PD_BIT (default 10) forced to 1 while `pdReq` is high. All other bits pass through unchanged.
- R9: `pdReq` stays high until reset, including through later runs that find a device.
- R10: After reset, `done`, `presentFlag`, `absentFlag` and `pdReq` are all 0. `done` lasts exactly one cycle per run. The result flags hold until the next accepted `start`, and they are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a monitoring run (accepted while idle) |
| linkStatus | input | STAT_W | Link status word; the low 4 bits are the detection field |
| ctrlIn | input | CTRL_W | PHY control word before power-down override |
| msTick | output | 1 | Derived millisecond tick |
| done | output | 1 | One-cycle pulse when a run ends |
| presentFlag | output | 1 | Last run found a device |
| absentFlag | output | 1 | Last run found no device |
| pdReq | output | 1 | Sticky PHY power-down request |
| ctrlOut | output | CTRL_W | PHY control word with power-down bit applied |

## Verification
A retry counter that is off by one moves `done` by exactly one check period. It can also turn the result of a final-check arrival from present to absent. Either error shows at the ports within one run. A tick divider or millisecond counter that loses or gains a count shifts every later check, and the error grows by a whole period per check. Sweeping the device-arrival point across every check therefore pins down the faulty stage from the cycle on which `done` appears. A power-down latch that fails to stick, or that disturbs other control bits, shows on `ctrlOut` in the cycle after the fault.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_WAIT  = 2'd2
  } dpm_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrTick;
    logic clrMs;
    logic clrRetry;
    logic incRetry;
    logic clrFlags;
    logic setPresent;
    logic setAbsent;
  } dpm_strobe_t;

endpackage

// File: rtl/dpm_tick_gen.sv
module dpm_tick_gen #(
  parameter int TICK_CYC = 250000
) (
  input  logic clk,
  input  logic rstN,
  input  logic restart,
  output logic tick
);
  localparam int TW = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CYC - 1);

  logic [TW-1:0] tickCnt;

  assign tick = (tickCnt == TICK_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (restart || tick) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end
endmodule

// File: rtl/dpm_datapath.sv
module dpm_datapath
  import dpm_pkg::*;
#(
  parameter int CLK_HZ     = 250_000_000,
  parameter int SPACING_MS = 25,
  parameter int MAX_RETRY  = 20,
  parameter int STAT_W     = 32,
  parameter int DET_W      = 4,
  parameter int CTRL_W     = 32,
  parameter int PD_BIT     = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpm_strobe_t       stb,
  input  logic [STAT_W-1:0] linkStatus,
  input  logic [CTRL_W-1:0] ctrlIn,
  output logic              msTick,
  output logic              detHit,
  output logic              msDone,
  output logic              retryLast,
  output logic              done,
  output logic              presentFlag,
  output logic              absentFlag,
  output logic              pdReq,
  output logic [CTRL_W-1:0] ctrlOut
);
  localparam int TICK_CYC = CLK_HZ / 1000;
  localparam int MW = $clog2(SPACING_MS + 1);
  localparam int RW = $clog2(MAX_RETRY + 1);
  localparam logic [MW-1:0] MS_LAST    = MW'(SPACING_MS - 1);
  localparam logic [RW-1:0] RETRY_LAST = RW'(MAX_RETRY);
  localparam logic [STAT_W-1:0] DET_MASK = STAT_W'((64'd1 << DET_W) - 64'd1);
  localparam logic [CTRL_W-1:0] PD_MASK  = CTRL_W'(64'd1 << PD_BIT);

  logic [MW-1:0] msCnt;
  logic [RW-1:0] retryCnt;

  dpm_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk     (clk),
    .rstN    (rstN),
    .restart (stb.clrTick),
    .tick    (msTick)
  );

  assign detHit    = |(linkStatus & DET_MASK);
  assign msDone    = msTick && (msCnt == MS_LAST);
  assign retryLast = (retryCnt == RETRY_LAST);
  assign ctrlOut   = pdReq ? (ctrlIn | PD_MASK) : ctrlIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msCnt <= '0;
    end else if (stb.clrMs) begin
      msCnt <= '0;
    end else if (msTick) begin
      msCnt <= msCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retryCnt <= '0;
    end else if (stb.clrRetry) begin
      retryCnt <= '0;
    end else if (stb.incRetry) begin
      retryCnt <= retryCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done        <= 1'b0;
      presentFlag <= 1'b0;
      absentFlag  <= 1'b0;
      pdReq       <= 1'b0;
    end else begin
      done <= stb.setPresent || stb.setAbsent;
      if (stb.clrFlags) begin
        presentFlag <= 1'b0;
        absentFlag  <= 1'b0;
      end else if (stb.setPresent) begin
        presentFlag <= 1'b1;
      end else if (stb.setAbsent) begin
        absentFlag  <= 1'b1;
      end
      if (stb.setAbsent) begin
        pdReq <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dpm_control.sv
module dpm_control
  import dpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        detHit,
  input  logic        msDone,
  input  logic        retryLast,
  output dpm_strobe_t stb
);
  dpm_state_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNxt;
    end
  end

  always_comb begin
    stateNxt = state;
    stb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stb.clrRetry = 1'b1;
          stb.clrFlags = 1'b1;
          stateNxt     = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (detHit) begin
          stb.setPresent = 1'b1;
          stateNxt       = ST_IDLE;
        end else if (retryLast) begin
          stb.setAbsent = 1'b1;
          stateNxt      = ST_IDLE;
        end else begin
          stb.incRetry = 1'b1;
          stb.clrTick  = 1'b1;
          stb.clrMs    = 1'b1;
          stateNxt     = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (msDone) begin
          stateNxt = ST_CHECK;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/dev_presence_monitor.sv
module dev_presence_monitor
  import dpm_pkg::*;
#(
  parameter int CLK_HZ     = 250_000_000,
  parameter int SPACING_MS = 25,
  parameter int MAX_RETRY  = 20,
  parameter int STAT_W     = 32,
  parameter int CTRL_W     = 32,
  parameter int PD_BIT     = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [STAT_W-1:0] linkStatus,
  input  logic [CTRL_W-1:0] ctrlIn,
  output logic              msTick,
  output logic              done,
  output logic              presentFlag,
  output logic              absentFlag,
  output logic              pdReq,
  output logic [CTRL_W-1:0] ctrlOut
);
  localparam int DET_W = 4;

  dpm_strobe_t stb;
  logic        detHit;
  logic        msDone;
  logic        retryLast;

  dpm_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .detHit    (detHit),
    .msDone    (msDone),
    .retryLast (retryLast),
    .stb       (stb)
  );

  dpm_datapath #(
    .CLK_HZ     (CLK_HZ),
    .SPACING_MS (SPACING_MS),
    .MAX_RETRY  (MAX_RETRY),
    .STAT_W     (STAT_W),
    .DET_W      (DET_W),
    .CTRL_W     (CTRL_W),
    .PD_BIT     (PD_BIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .linkStatus  (linkStatus),
    .ctrlIn      (ctrlIn),
    .msTick      (msTick),
    .detHit      (detHit),
    .msDone      (msDone),
    .retryLast   (retryLast),
    .done        (done),
    .presentFlag (presentFlag),
    .absentFlag  (absentFlag),
    .pdReq       (pdReq),
    .ctrlOut     (ctrlOut)
  );
endmodule

// File: rtl/dev_presence_monitor_chk.sv
module dev_presence_monitor_chk #(
  parameter int CTRL_W = 32,
  parameter int PD_BIT = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              msTick,
  input logic              done,
  input logic              presentFlag,
  input logic              absentFlag,
  input logic              pdReq,
  input logic [CTRL_W-1:0] ctrlIn,
  input logic [CTRL_W-1:0] ctrlOut
);
  localparam logic [CTRL_W-1:0] PD_MASK = CTRL_W'(64'd1 << PD_BIT);

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rstN) msTick |=> !msTick); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R10
  AST_DONE_RESULT: assert property (@(posedge clk) disable iff (!rstN) done |-> (presentFlag ^ absentFlag)); // R10
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(presentFlag && absentFlag)); // R10
  AST_ABSENT_PD: assert property (@(posedge clk) disable iff (!rstN) $rose(absentFlag) |-> pdReq); // R7
  AST_PD_STICKY: assert property (@(posedge clk) disable iff (!rstN) pdReq |=> pdReq); // R9
  AST_PD_BIT_SET: assert property (@(posedge clk) disable iff (!rstN) pdReq |-> ctrlOut[PD_BIT]); // R8
  AST_OTHER_BITS: assert property (@(posedge clk) disable iff (!rstN) (ctrlOut & ~PD_MASK) == (ctrlIn & ~PD_MASK)); // R8
  AST_NO_PD_PASS: assert property (@(posedge clk) disable iff (!rstN) !pdReq |-> (ctrlOut == ctrlIn)); // R8
endmodule

bind dev_presence_monitor dev_presence_monitor_chk #(
  .CTRL_W (CTRL_W),
  .PD_BIT (PD_BIT)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .msTick      (msTick),
  .done        (done),
  .presentFlag (presentFlag),
  .absentFlag  (absentFlag),
  .pdReq       (pdReq),
  .ctrlIn      (ctrlIn),
  .ctrlOut     (ctrlOut)
);

// File: tb/dev_presence_monitor_bench.sv
`timescale 1ns/1ps
module dev_presence_monitor_bench;
  localparam int CLK_HZ     = 4000;
  localparam int SPACING_MS = 3;
  localparam int MAX_RETRY  = 4;
  localparam int STAT_W     = 8;
  localparam int CTRL_W     = 16;
  localparam int PD_BIT     = 10;
  localparam int TICK       = CLK_HZ / 1000;
  localparam int PER        = SPACING_MS * TICK + 1;
  localparam int LAST_EDGE  = 1 + MAX_RETRY * PER;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [STAT_W-1:0] linkStatus = '0;
  logic [CTRL_W-1:0] ctrlIn = 16'h1234;
  logic              msTick, done, presentFlag, absentFlag, pdReq;
  logic [CTRL_W-1:0] ctrlOut;

  int chkCnt = 0;
  int errCnt = 0;

  always #2 clk = ~clk;

  dev_presence_monitor #(
    .CLK_HZ(CLK_HZ), .SPACING_MS(SPACING_MS), .MAX_RETRY(MAX_RETRY),
    .STAT_W(STAT_W), .CTRL_W(CTRL_W), .PD_BIT(PD_BIT)
  ) u_dev_presence_monitor (
    .clk(clk), .rstN(rstN), .start(start), .linkStatus(linkStatus),
    .ctrlIn(ctrlIn), .msTick(msTick), .done(done), .presentFlag(presentFlag),
    .absentFlag(absentFlag), .pdReq(pdReq), .ctrlOut(ctrlOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Run one monitoring pass. arriveAt < 0: no device (only upper status bits set).
  // Otherwise the detection field turns nonzero just in time for check arriveAt.
  task automatic runPass(input int arriveAt, input bit midStart,
                         output int doneAt, output int extraDone);
    logic [STAT_W-1:0] pat;
    pat = arriveAt < 0 ? 8'hF0
        : {4'(arriveAt * 3 + 5), 4'((arriveAt % 15) + 1)};
    doneAt = -1;
    extraDone = 0;
    @(negedge clk);
    linkStatus = (arriveAt == 0 || arriveAt < 0) ? pat : 8'h00;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int n = 1; n <= LAST_EDGE + 3; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (done) begin
        if (doneAt < 0) doneAt = n; else extraDone++;
      end
      if (arriveAt > 0 && n == 1 + (arriveAt - 1) * PER) linkStatus = pat;
      start = midStart && (n == 5);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", chkCnt, errCnt);
    $finish;
  end

  initial begin
    int doneAt, extra, t0, t1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(done == 0 && presentFlag == 0 && absentFlag == 0, "R10", "reset flags",
          {done, presentFlag, absentFlag}, 0);
    check(pdReq == 0, "R10", "reset pdReq", pdReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(ctrlOut == ctrlIn, "R8", "pass-through before power-down", ctrlOut, ctrlIn);

    // R1 idle tick spacing
    t0 = 0; t1 = 0;
    for (int c = 0; c < 4 * TICK && t1 == 0; c++) begin
      @(negedge clk);
      if (msTick) begin
        if (t0 == 0) t0 = c + 1; else t1 = c + 1;
      end
    end
    check(t1 - t0 == TICK, "R1", "idle tick period", t1 - t0, TICK);

    // R3/R5/R6 sweep arrival over every check, R2 with a stray start on one pass
    for (int k = 0; k <= MAX_RETRY; k++) begin
      runPass(k, k == 2, doneAt, extra);
      check(doneAt == 1 + k * PER, k == MAX_RETRY ? "R6" : "R5", "done edge",
            doneAt, 1 + k * PER);
      check(presentFlag && !absentFlag, "R3", "present result", {presentFlag, absentFlag}, 2);
      check(extra == 0, k == 2 ? "R2" : "R10", "single done pulse", extra, 0);
      check(pdReq == 0, "R9", "no power-down after present", pdReq, 0);
    end

    // R4/R7 absent: only upper bits set
    runPass(-1, 1'b0, doneAt, extra);
    check(doneAt == LAST_EDGE, "R7", "absent done edge", doneAt, LAST_EDGE);
    check(absentFlag && !presentFlag, "R4", "upper bits ignored -> absent",
          {presentFlag, absentFlag}, 1);
    check(pdReq == 1, "R7", "pdReq after absent", pdReq, 1);
    check(ctrlOut == (ctrlIn | 16'h0400), "R8", "pd bit 10 set", ctrlOut, ctrlIn | 16'h0400);
    ctrlIn = 16'hABCD;
    @(negedge clk);
    check(ctrlOut == 16'hAFCD, "R8", "other bits follow ctrlIn", ctrlOut, 16'hAFCD);

    // R9 sticky through a present run; R10 flags flip on next start
    runPass(1, 1'b0, doneAt, extra);
    check(presentFlag && !absentFlag, "R10", "flags replaced by new run",
          {presentFlag, absentFlag}, 2);
    check(pdReq == 1, "R9", "pdReq sticky across present run", pdReq, 1);
    repeat (7) @(negedge clk);
    check(presentFlag == 1, "R10", "present flag held", presentFlag, 1);

    rstN = 1'b0;
    @(negedge clk);
    check(pdReq == 0, "R9", "pdReq cleared by reset", pdReq, 0);
    check(ctrlOut == ctrlIn, "R8", "pass-through after reset", ctrlOut, ctrlIn);

    $display("Simulation finished: %0d checks, %0d errors", chkCnt, errCnt);
    $finish;
  end
endmodule